// File: doc/BRIEF.md
# Per-Word Permission-Tagged Memory

This block is a small word-addressed store in which each word carries a permission tag next to its data. A user-side requester issues one access per cycle, a data read, a data write or an instruction fetch, and the block compares the kind of access against the tag of the word it addresses. If the tag grants that kind, the access completes. If not, the access has no side effect and the response carries an access-violation fault. Rights are decided word by word on every access, never for a whole region.

Tags can only be set from a separate privileged port. That port writes the data and the tag of one word together and is never subject to the permission check. After reset every tag denies everything, so privileged software must grant rights before any user access can succeed. Data width, depth and tag width are parameters. The low two tag bits hold the permission code, and any set bit above them removes all rights.

Top module: `tagmem_checker`

## Requirements
- R1: After reset every tag is no-access, every data word is zero and `rsp_valid` is low, so every user access made before any privileged write faults.
- R2: The permission code sits in tag bits [1:0]: 0 no access, 1 read-only, 2 read/write, 3 execute-only. A tag with any bit above bit 1 set grants no access of any kind.
- R3: A data read (kind 0) is granted when the code is read-only or read/write, and it returns the stored word with the fault flag low.
- R4: A data write (kind 1) is granted only when the code is read/write. It replaces the data, leaves the tag unchanged, and responds with the fault flag low and zero data.
- R5: A fetch (kind 2) is granted only when the code is execute-only, and it returns the stored word with the fault flag low.
- R6: A refused access changes neither the data nor the tag of any word, and its response has the fault flag high and zero data.
- R7: A privileged write sets the data and the tag of one word whatever the current tag, and it produces no response.
- R8: Every user request gives exactly one response on the cycle after it is accepted, and `rsp_valid` is low on every other cycle. Permission and data come out with the same one-cycle latency.
- R9: Request kind 3 is reserved and always faults.
- R10: A user access checks and reads the state as it stood before the clock edge. When a privileged write and a granted user write target the same word in the same cycle, the privileged write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User access request |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_addr | input | ADDR_W | Word address of the user access |
| req_wdata | input | DATA_W | Write data for a user write |
| priv_we | input | 1 | Privileged data-and-tag write |
| priv_addr | input | ADDR_W | Word address of the privileged write |
| priv_data | input | DATA_W | Data for the privileged write |
| priv_tag | input | TAG_W | Tag for the privileged write |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_data | output | DATA_W | Read or fetch data, zero on writes and faults |
| rsp_fault | output | 1 | Access-violation flag |

## Verification
A directed pass sweeps every request kind against every tag code, plus a tag with an upper bit set. This separates a wrong grant table from a wrong decode of the tag field. Refused writes are followed by privileged regrants and reads, which show whether the faulting write left the word untouched. Same-cycle collisions of privileged and user writes, and reads issued in the cycle of a privileged write, confirm that the old state is what gets checked and that the privileged write wins. A long pseudo-random stream of mixed requests and tag rewrites is then compared against a behavioural model on every cycle.

// File: rtl/tmc_pkg.sv
`timescale 1ns/1ps
package tmc_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [1:0] CODE_NONE = 2'd0;
    localparam logic [1:0] CODE_RO   = 2'd1;
    localparam logic [1:0] CODE_RW   = 2'd2;
    localparam logic [1:0] CODE_XO   = 2'd3;

    // Grant table: the access kind against the two-bit permission code.
    function automatic logic kind_granted(acc_kind_e kind, logic [1:0] code);
        logic ok;
        unique case (kind)
            KIND_READ:  ok = (code == CODE_RO) || (code == CODE_RW);
            KIND_WRITE: ok = (code == CODE_RW);
            KIND_FETCH: ok = (code == CODE_XO);
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tmc_perm_check.sv
`timescale 1ns/1ps
module tmc_perm_check
    import tmc_pkg::*;
#(
    parameter int TAG_W = 2
) (
    input  acc_kind_e        kind,
    input  logic [TAG_W-1:0] tag,
    output logic             granted
);
    logic upper_clear;

    generate
        if (TAG_W > 2) begin : g_upper
            assign upper_clear = (tag[TAG_W-1:2] == '0);
        end else begin : g_no_upper
            assign upper_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        granted = upper_clear && kind_granted(kind, tag[1:0]);
    end
endmodule

// File: rtl/tmc_store.sv
`timescale 1ns/1ps
module tmc_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag,
    input  logic              usr_we,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_data,
    input  logic              priv_we,
    input  logic [ADDR_W-1:0] priv_addr,
    input  logic [DATA_W-1:0] priv_data,
    input  logic [TAG_W-1:0]  priv_tag
);
    typedef struct {
        logic [DATA_W-1:0] word [DEPTH];
        logic [TAG_W-1:0]  perm [DEPTH];
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (usr_we) begin
            st_d.word[usr_addr] = usr_data;
        end
        // The privileged write comes last, so it wins a same-word collision.
        if (priv_we) begin
            st_d.word[priv_addr] = priv_data;
            st_d.perm[priv_addr] = priv_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.word[i] <= '0;
                st_q.perm[i] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.word[rd_addr];
    assign rd_tag  = st_q.perm[rd_addr];
endmodule

// File: rtl/tagmem_checker.sv
`timescale 1ns/1ps
module tagmem_checker
    import tmc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              priv_we,
    input  logic [ADDR_W-1:0] priv_addr,
    input  logic [DATA_W-1:0] priv_data,
    input  logic [TAG_W-1:0]  priv_tag,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_fault
);
    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t      rsp_d, rsp_q;
    acc_kind_e kind;
    logic [DATA_W-1:0] cur_data;
    logic [TAG_W-1:0]  cur_tag;
    logic              granted;
    logic              usr_we;

    assign kind = acc_kind_e'(req_kind);

    tmc_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .TAG_W  (TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (req_addr),
        .rd_data   (cur_data),
        .rd_tag    (cur_tag),
        .usr_we    (usr_we),
        .usr_addr  (req_addr),
        .usr_data  (req_wdata),
        .priv_we   (priv_we),
        .priv_addr (priv_addr),
        .priv_data (priv_data),
        .priv_tag  (priv_tag)
    );

    tmc_perm_check #(
        .TAG_W (TAG_W)
    ) u_perm (
        .kind    (kind),
        .tag     (cur_tag),
        .granted (granted)
    );

    assign usr_we = req_valid && granted && (kind == KIND_WRITE);

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = !granted;
            if (granted && (kind == KIND_READ || kind == KIND_FETCH)) begin
                rsp_d.data = cur_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_data  = rsp_q.data;
endmodule

// File: rtl/tmc_checker.sv
`timescale 1ns/1ps
module tmc_checker #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              priv_we,
    input logic [ADDR_W-1:0] priv_addr,
    input logic [TAG_W-1:0]  priv_tag,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_fault
);
    a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r6_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_data == '0));

    a_r9_reserved_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> rsp_fault);

    a_r4_write_rsp_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1) |=> (rsp_data == '0));

    a_r2_none_tag_faults: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(priv_we) && $past(priv_tag) == '0 && !priv_we
         && req_valid && req_addr == $past(priv_addr)) |=> rsp_fault);
endmodule

bind tagmem_checker tmc_checker #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .TAG_W  (TAG_W)
) u_tmc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .priv_we   (priv_we),
    .priv_addr (priv_addr),
    .priv_tag  (priv_tag),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_fault (rsp_fault)
);

// File: tb/tagmem_checker_bench.sv
`timescale 1ns/1ps
module tagmem_checker_bench;
    localparam int DW = 32;
    localparam int DP = 16;
    localparam int TW = 3;
    localparam int AW = $clog2(DP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          priv_we = 1'b0;
    logic [AW-1:0] priv_addr = '0;
    logic [DW-1:0] priv_data = '0;
    logic [TW-1:0] priv_tag = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_fault;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    logic [DW-1:0] m_word [DP];
    int            m_tag  [DP];

    always #2.5 clk = ~clk;

    tagmem_checker #(.DATA_W(DW), .DEPTH(DP), .TAG_W(TW)) u_tagmem_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .priv_we(priv_we),
        .priv_addr(priv_addr), .priv_data(priv_data), .priv_tag(priv_tag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
    );

    function automatic bit allowed(int kind, int tag);
        if (tag > 3) return 1'b0;
        case (kind)
            0: return tag == 1 || tag == 2;
            1: return tag == 2;
            2: return tag == 3;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(int kind, bit ok, int tag);
        if (!ok && kind == 3) return "R9";
        if (!ok && tag > 3)   return "R2";
        if (!ok)              return "R6";
        case (kind)
            0: return "R3";
            1: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One clock: drive, predict from the model, advance, compare.
    task automatic cyc(bit rv, int k, int a, logic [DW-1:0] wd,
                       bit pw, int pa, logic [DW-1:0] pd, int pt, string force_rq);
        bit ok;
        logic [DW-1:0] ed;
        string rq;
        req_valid = rv; req_kind = 2'(k); req_addr = AW'(a); req_wdata = wd;
        priv_we = pw; priv_addr = AW'(pa); priv_data = pd; priv_tag = TW'(pt);
        ok = rv && allowed(k, m_tag[a]);
        ed = (ok && (k == 0 || k == 2)) ? m_word[a] : '0;
        rq = rv ? tag_of(k, ok, m_tag[a]) : "R8";
        if (force_rq != "") rq = force_rq;
        if (ok && k == 1 && !(pw && pa == a)) m_word[a] = wd;
        if (pw) begin m_word[pa] = pd; m_tag[pa] = pt; end
        @(posedge clk); #1;
        check(rq, "rsp_valid", DW'(rsp_valid), DW'(rv));
        if (rv) begin
            check(rq, "rsp_fault", DW'(rsp_fault), DW'(!ok));
            check(rq, "rsp_data", rsp_data, ed);
        end
    endtask

    task automatic priv(int pa, logic [DW-1:0] pd, int pt);
        cyc(0, 0, 0, '0, 1, pa, pd, pt, "R7");
    endtask

    task automatic idle();
        cyc(0, 0, 0, '0, 0, 0, '0, 0, "R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < DP; i++) begin m_word[i] = '0; m_tag[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1", "rsp_valid after reset", DW'(rsp_valid), '0);

        // R1: every word denies every kind after reset
        for (int a = 0; a < DP; a++) cyc(1, a % 3, a, 32'h1111_0000 + a, 0, 0, '0, 0, "R1");

        // R7: privileged grants over the whole array, codes cycling 0..3 plus 4..7
        for (int a = 0; a < DP; a++) priv(a, 32'hA5A5_0000 + a, a % 8);

        // R2/R3/R4/R5/R6/R9: every kind against every tag
        for (int a = 0; a < 8; a++)
            for (int k = 0; k < 4; k++)
                cyc(1, k, a, 32'hC0DE_0000 + (a << 4) + k, 0, 0, '0, 0, "");
        for (int a = 0; a < 8; a++) cyc(1, 0, a, '0, 0, 0, '0, 0, "");

        // R6: refused write to a read-only word, then regrant and read back
        priv(5, 32'h0000_BEEF, 1);
        cyc(1, 1, 5, 32'hDEAD_DEAD, 0, 0, '0, 0, "R6");
        cyc(1, 0, 5, '0, 0, 0, '0, 0, "R6");
        cyc(1, 2, 5, '0, 0, 0, '0, 0, "R6");
        priv(5, 32'h0000_BEEF, 2);
        cyc(1, 0, 5, '0, 0, 0, '0, 0, "R6");

        // R4: granted write keeps the tag: a fetch still faults, a read sees the data
        priv(6, 32'h1, 2);
        cyc(1, 1, 6, 32'h600D_F00D, 0, 0, '0, 0, "R4");
        cyc(1, 2, 6, '0, 0, 0, '0, 0, "R4");
        cyc(1, 0, 6, '0, 0, 0, '0, 0, "R4");

        // R10: collision on one word, privileged side wins
        priv(7, 32'h7, 2);
        cyc(1, 1, 7, 32'hAAAA_AAAA, 1, 7, 32'h5555_5555, 2, "R10");
        cyc(1, 0, 7, '0, 0, 0, '0, 0, "R10");
        // R10: read sees the old state in the cycle of a privileged rewrite
        cyc(1, 0, 7, '0, 1, 7, 32'h9999_0000, 0, "R10");
        cyc(1, 0, 7, '0, 0, 0, '0, 0, "R10");
        // R10: granted write alongside a privileged write to another word
        priv(8, 32'h8, 2);
        cyc(1, 1, 8, 32'h8888_0001, 1, 9, 32'h9999_0009, 3, "R10");
        cyc(1, 0, 8, '0, 0, 0, '0, 0, "R10");
        cyc(1, 2, 9, '0, 0, 0, '0, 0, "R10");

        // R8: idle cycles and back-to-back requests
        idle(); idle();

        // Mixed pseudo-random stream
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 1500; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cyc(lf[0] | lf[1], int'(lf[3:2]), int'(lf[7:4]), {lf[15:0], lf[31:16]},
                lf[8] & lf[9], int'(lf[13:10]), lf ^ 32'h3C3C_3C3C, int'(lf[18:16]), "");
        end
        idle();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule